// File: doc/BRIEF.md
# Programmable Hysteretic Unipolar Switch Core

This block sets the supply-current level of a two-wire unipolar magnetic switch. Its input is a signed field sample that is already digital, with a valid strobe. It compares each valid sample against an operate threshold and a release threshold and drives a single bit that selects the high or the low current state. A six-bit trim code sets the operate threshold. The release threshold sits a fixed hysteresis below it. With that gap the output switches cleanly when the field is noisy.

The default polarity enters the low current state when a strong south field is present. A strap input gives the reverse mapping. After reset the output is always in the high current state. It stays there until a valid sample crosses a threshold that moves it. Field samples and thresholds share one signed scale in units of 0.1 G: positive values mean south and negative values mean north.

Top module: `hsw_core`

## Requirements
- R1: With `rev_pol`=0, a valid sample strictly greater than the operate threshold makes `cur_high` 0 after the next clock edge. A sample equal to the threshold does not switch.
- R2: With `rev_pol`=0, a valid sample strictly less than the release threshold makes `cur_high` 1 after the next clock edge. A sample equal to the threshold does not switch.
- R3: With `rev_pol`=1, a valid sample above the operate threshold makes `cur_high` 1, and a valid sample below the release threshold makes `cur_high` 0.
- R4: The release threshold always equals the operate threshold minus the fixed parameter HYS (default 150).
- R5: While `rst_n` is low, and after it is released, `cur_high` is 1 for either polarity.
- R6: A cycle with `smp_vld`=0 leaves `cur_high` unchanged, whatever value is on `field_smp`.
- R7: A valid sample between the release and operate thresholds, both ends included, leaves `cur_high` unchanged. This includes the first samples after reset.
- R8: The operate threshold equals INIT + code × STEP (defaults -20 and 48). It is loaded during reset and updated one clock edge after `trim_code` changes.
- R9: All comparisons are signed two's-complement, so north (negative) samples compare correctly against negative thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_smp | input | FIELD_W (16) | Signed field sample, 0.1 G units, positive = south |
| smp_vld | input | 1 | Marks `field_smp` as a new sample to evaluate |
| trim_code | input | CODE_W (6) | Effective operate-point trim code |
| rev_pol | input | 1 | 0 = low current above operate, 1 = reversed mapping |
| cur_high | output | 1 | 1 = high supply-current state, 0 = low |

## Verification
The properties assume that `rev_pol` is a strap that changes only while reset is held. They also assume that INIT, STEP and HYS are chosen so that both thresholds fit in FIELD_W bits for every code. The bench changes polarity only inside a reset pulse and uses the default parameters, whose thresholds range from -170 to 3004. After each new trim code, the bench waits for the threshold register to reload before it sends the next sample. Every sample is held for exactly one edge, so the expected output is known at each check.

// File: rtl/hsw_pkg.sv
// Shared types and arithmetic for the hysteretic switch core.
// Assumes threshold parameters are given in 0.1 G units.
package hsw_pkg;

    // Supply-current level selected by the switch output.
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_t;

    // Operate threshold for a trim code: offset plus linear step.
    function automatic int op_of(input int init, input int step, input int code);
        return init + code * step;
    endfunction

endpackage

// File: rtl/hsw_thresh.sv
// Threshold generator: turns the trim code into registered operate and
// release thresholds. Assumes all results fit in THR_W signed bits.
module hsw_thresh #(
    parameter int CODE_W = 6,
    parameter int THR_W  = 16,
    parameter int INIT   = -20,
    parameter int STEP   = 48,
    parameter int HYS    = 150
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CODE_W-1:0]       trim_code,
    output logic signed [THR_W-1:0] op_thr,
    output logic signed [THR_W-1:0] rel_thr
);
    import hsw_pkg::*;

    logic [CODE_W-1:0]       code_q;
    logic signed [THR_W-1:0] op_q;
    logic signed [THR_W-1:0] rel_q;
    int                      op_next;
    logic                    code_chg;

    // Find the new threshold and detect a change of the trim code.
    always_comb begin
        op_next  = op_of(INIT, STEP, int'(trim_code));
        code_chg = (trim_code != code_q);
    end

    // Load during reset, then reload only when the code changes.
    always_ff @(posedge clk) begin
        if (!rst_n || code_chg) begin
            code_q <= trim_code;
            op_q   <= THR_W'(op_next);
            rel_q  <= THR_W'(op_next - HYS);
        end
    end

    assign op_thr  = op_q;
    assign rel_thr = rel_q;

endmodule

// File: rtl/hsw_compare.sv
// Signed comparator pair: flags a sample above the operate threshold or
// below the release threshold. Equality raises neither flag.
module hsw_compare #(
    parameter int THR_W = 16
) (
    input  logic signed [THR_W-1:0] field,
    input  logic signed [THR_W-1:0] op_thr,
    input  logic signed [THR_W-1:0] rel_thr,
    output logic                    above_op,
    output logic                    below_rel
);
    // Strict signed comparisons against both thresholds.
    always_comb begin
        above_op  = (field > op_thr);
        below_rel = (field < rel_thr);
    end

endmodule

// File: rtl/hsw_state.sv
// Output state holder: keeps the current-level bit and changes it only on
// valid samples that cross a threshold. Assumes rev_pol is static.
module hsw_state (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    input  logic rev_pol,
    input  logic above_op,
    input  logic below_rel,
    output logic cur_high
);
    import hsw_pkg::*;

    level_t lvl_q;
    level_t lvl_d;
    level_t lvl_on;
    level_t lvl_off;

    // Map the crossing direction onto a current level by polarity.
    always_comb begin
        lvl_on  = rev_pol ? LVL_HIGH : LVL_LOW;
        lvl_off = rev_pol ? LVL_LOW  : LVL_HIGH;
        lvl_d   = lvl_q;
        if (smp_vld) begin
            if (above_op)
                lvl_d = lvl_on;
            else if (below_rel)
                lvl_d = lvl_off;
        end
    end

    // Hold the level. Reset forces the high current state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_q <= LVL_HIGH;
        else
            lvl_q <= lvl_d;
    end

    assign cur_high = (lvl_q == LVL_HIGH);

endmodule

// File: rtl/hsw_core.sv
// Top of the hysteretic unipolar switch core: trimmed thresholds, signed
// compare, and a polarity-selectable current-level output.
// Assumes field samples and thresholds share the same signed scale.
module hsw_core #(
    parameter int FIELD_W = 16,
    parameter int CODE_W  = 6,
    parameter int INIT    = -20,
    parameter int STEP    = 48,
    parameter int HYS     = 150
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic signed [FIELD_W-1:0] field_smp,
    input  logic                      smp_vld,
    input  logic [CODE_W-1:0]         trim_code,
    input  logic                      rev_pol,
    output logic                      cur_high
);
    logic signed [FIELD_W-1:0] op_thr;
    logic signed [FIELD_W-1:0] rel_thr;
    logic                      above_op;
    logic                      below_rel;

    hsw_thresh #(
        .CODE_W(CODE_W), .THR_W(FIELD_W),
        .INIT(INIT), .STEP(STEP), .HYS(HYS)
    ) u_thresh (
        .clk(clk), .rst_n(rst_n), .trim_code(trim_code),
        .op_thr(op_thr), .rel_thr(rel_thr)
    );

    hsw_compare #(.THR_W(FIELD_W)) u_cmp (
        .field(field_smp), .op_thr(op_thr), .rel_thr(rel_thr),
        .above_op(above_op), .below_rel(below_rel)
    );

    hsw_state u_state (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .rev_pol(rev_pol),
        .above_op(above_op), .below_rel(below_rel), .cur_high(cur_high)
    );

endmodule

// File: rtl/hsw_core_chk.sv
// Property checker for hsw_core, attached through bind.
// Assumes rev_pol only changes while reset is held.
module hsw_core_chk #(
    parameter int FIELD_W = 16,
    parameter int CODE_W  = 6,
    parameter int INIT    = -20,
    parameter int STEP    = 48,
    parameter int HYS     = 150
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic signed [FIELD_W-1:0] field_smp,
    input logic                      smp_vld,
    input logic [CODE_W-1:0]         trim_code,
    input logic                      rev_pol,
    input logic                      cur_high,
    input logic signed [FIELD_W-1:0] op_thr,
    input logic signed [FIELD_W-1:0] rel_thr
);
    p_pwrup_high_r5: assert property (@(posedge clk)
        !rst_n |=> cur_high);

    p_norm_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && !rev_pol && (field_smp > op_thr) |=> !cur_high);

    p_norm_rel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && !rev_pol && (field_smp < rel_thr) |=> cur_high);

    p_rev_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && rev_pol && (field_smp > op_thr) |=> cur_high);

    p_rev_rel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && rev_pol && (field_smp < rel_thr) |=> !cur_high);

    p_hys_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(op_thr) - int'(rel_thr) == HYS);

    p_no_vld_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(cur_high));

    p_band_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && (field_smp <= op_thr) && (field_smp >= rel_thr)
        |=> $stable(cur_high));

    p_thr_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(trim_code) |-> int'(op_thr) == INIT + int'(trim_code) * STEP);

endmodule

bind hsw_core hsw_core_chk #(
    .FIELD_W(FIELD_W), .CODE_W(CODE_W),
    .INIT(INIT), .STEP(STEP), .HYS(HYS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .field_smp(field_smp), .smp_vld(smp_vld),
    .trim_code(trim_code), .rev_pol(rev_pol), .cur_high(cur_high),
    .op_thr(op_thr), .rel_thr(rel_thr)
);

// File: tb/hsw_core_bench.sv
// Directed bench for hsw_core with default parameters:
// op = -20 + 48*code, rel = op - 150.
module hsw_core_bench;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [15:0] field_smp = '0;
    logic               smp_vld = 1'b0;
    logic [5:0]         trim_code = '0;
    logic               rev_pol = 1'b0;
    logic               cur_high;

    int total = 0;
    int bad   = 0;

    hsw_core u_hsw_core (
        .clk(clk), .rst_n(rst_n), .field_smp(field_smp), .smp_vld(smp_vld),
        .trim_code(trim_code), .rev_pol(rev_pol), .cur_high(cur_high)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: cur_high=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Send one sample for one edge, then check the output.
    task automatic sample(input int f, input logic v, input string req, input logic exp);
        @(negedge clk);
        field_smp = 16'(f);
        smp_vld   = v;
        @(negedge clk);
        smp_vld   = 1'b0;
        chk(req, cur_high, exp);
    endtask

    task automatic do_reset(input logic pol);
        @(negedge clk);
        rst_n   = 1'b0;
        rev_pol = pol;
        smp_vld = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 during reset", cur_high, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 after reset", cur_high, 1'b1);
    endtask

    task automatic set_code(input logic [5:0] c);
        @(negedge clk);
        trim_code = c;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_powerup_band;
        do_reset(1'b0);
        sample(-100, 1'b1, "R7 band at power-up", 1'b1);
    endtask

    task automatic t_normal_code10;          // op 460, rel 310
        set_code(6'd10);
        sample(460, 1'b1, "R1 equal to op holds", 1'b1);
        sample(461, 1'b1, "R1 R8 above op", 1'b0);
        sample(400, 1'b1, "R7 band holds low", 1'b0);
        sample(310, 1'b1, "R2 R4 equal to rel holds", 1'b0);
        sample(309, 1'b1, "R2 R4 below rel", 1'b1);
    endtask

    task automatic t_ignore_invalid;
        sample(1000, 1'b0, "R6 invalid high field ignored", 1'b1);
        sample(461, 1'b1, "R1 switch low", 1'b0);
        sample(-500, 1'b0, "R6 invalid low field ignored", 1'b0);
        sample(309, 1'b1, "R2 back high", 1'b1);
    endtask

    task automatic t_code_max;               // op 3004, rel 2854
        set_code(6'd63);
        sample(3000, 1'b1, "R8 below new op holds", 1'b1);
        sample(3005, 1'b1, "R8 above new op", 1'b0);
        sample(2853, 1'b1, "R8 R4 below new rel", 1'b1);
    endtask

    task automatic t_north_signed;           // op -20, rel -170
        set_code(6'd0);
        sample(-19, 1'b1, "R9 R8 above negative op", 1'b0);
        sample(-170, 1'b1, "R9 equal to negative rel holds", 1'b0);
        sample(-171, 1'b1, "R9 below negative rel", 1'b1);
    endtask

    task automatic t_reverse;
        do_reset(1'b1);
        set_code(6'd10);
        sample(400, 1'b1, "R7 R3 band holds high", 1'b1);
        sample(309, 1'b1, "R3 below rel goes low", 1'b0);
        sample(460, 1'b1, "R3 equal to op holds", 1'b0);
        sample(461, 1'b1, "R3 above op goes high", 1'b1);
        sample(-300, 1'b0, "R6 R3 invalid ignored", 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_powerup_band();
        t_normal_code10();
        t_ignore_invalid();
        t_code_max();
        t_north_signed();
        t_reverse();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule